// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive-Ready Request

This block is the receive half of an asynchronous serial port. It samples the serial line at sixteen times the bit rate and finds a falling edge. It confirms the start bit half a bit later, then collects 5 to 8 data bits with the least significant bit first. An even or odd parity bit may follow, and then one or two stop bits. The start, parity and stop bits are removed. Only the data character is stored, either in a 16-entry receive queue or, with the queue turned off, in a single holding slot. Each pulse on `rd_en` removes the oldest character.

A programmable divider sets the oversampling rate. Each received character can raise a parity, framing, overrun or line-break pulse. The active-low request `rxrdy_n` tells a DMA engine or a processor that data is waiting, and it has two behaviours. In the simple behaviour the request is asserted while anything is held. In the batched behaviour the request is asserted when the queue fill reaches a chosen threshold, or when a character has gone unread too long. Once asserted, it stays asserted until the queue is completely empty. The batched behaviour is selected only when the queue is enabled and the DMA-select input is high.

Top module: `uart_rx_dmareq`

## Requirements
- R1: A frame is one low start bit, `cfg_len`+5 data bits sent least significant first (`cfg_len` 0..3 selects 5..8), an optional parity bit and one or two high stop bits. The character appears on `rd_data` right-aligned, with unused upper bits zero.
- R2: Frames with 7 data bits, parity and two stop bits are received correctly, including frames sent back to back with no idle time between them.
- R3: With `cfg_par_en`=1 the parity bit is checked. `cfg_par_odd`=0 means even parity (data bits plus parity bit hold an even number of ones) and 1 means odd parity. A mismatch gives a one-cycle pulse on `err_parity`, and the character is still stored.
- R4: A stop bit sampled low gives a one-cycle `err_frame` pulse. The character is stored, and no new start bit is searched for until the line has returned high.
- R5: A start bit is accepted only if the line is still low at its mid-point. A low glitch shorter than half a bit stores nothing.
- R6: With `cfg_fifo_en`=1, up to 16 characters are held and read back in arrival order. With `cfg_fifo_en`=0, one character is held. `rd_valid` is high while anything is held.
- R7: A character that arrives when the storage is full is discarded with a one-cycle `err_overrun` pulse, and the characters already held are unchanged.
- R8: In the simple behaviour (`cfg_dma_sel`=0 or `cfg_fifo_en`=0), `rxrdy_n` is low exactly when at least one character was held in the previous cycle. After reset it is high.
- R9: In the batched behaviour (`cfg_dma_sel`=1 and `cfg_fifo_en`=1), `rxrdy_n` goes low once the fill reaches the threshold chosen by `cfg_trig`: 0→1, 1→4, 2→8, 3→14 characters.
- R10: If the storage is non-empty and nothing has been stored or read for 4 character times (4×16×frame-bits ticks), `rx_timeout` rises. In the batched behaviour this also drives `rxrdy_n` low.
- R11: In the batched behaviour, once `rxrdy_n` is low it stays low until the storage is empty, even if the fill drops below the threshold.
- R12: A line held low through the whole frame, stop bits included, stores a zero character and pulses `brk_det` (not `err_frame`). Reception resumes only after the line has gone high.
- R13: The oversampling tick occurs once every `cfg_div`+1 clocks, so one bit lasts 16×(`cfg_div`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Tick divider; tick period is cfg_div+1 clocks |
| cfg_len | input | 2 | Data length code, 5+cfg_len bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits expected |
| cfg_fifo_en | input | 1 | 1 = 16-entry queue, 0 = single slot |
| cfg_dma_sel | input | 1 | Selects the batched request behaviour (needs cfg_fifo_en) |
| cfg_trig | input | 2 | Batched threshold code |
| rx_serial | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Remove the oldest character |
| rd_data | output | 8 | Oldest held character |
| rd_valid | output | 1 | At least one character held |
| rxrdy_n | output | 1 | Receive-ready request, active low |
| rx_timeout | output | 1 | Character timeout pending |
| err_parity | output | 1 | Parity mismatch pulse |
| err_frame | output | 1 | Framing error pulse |
| err_overrun | output | 1 | Discarded-character pulse |
| brk_det | output | 1 | Line-break pulse |

## Verification
The bench keeps the default 16-entry depth and a 4-character timeout. It runs most frames with `cfg_div`=0, so a bit lasts 16 clocks. That keeps full-queue overrun, the 14-character threshold region and the roughly 700-clock timeout within a short run. One frame is sent with `cfg_div`=2 to show that the divider stretches the bit time. A behavioural queue in the bench predicts every stored character and overrun. A per-clock comparison also tracks the simple request behaviour against `rd_valid`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int CHAR_W = 8;
    localparam int OSR    = 16;
    localparam int OS_W   = $clog2(OSR);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_st_e;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_s;

    baud_s q, d;

    always_comb begin
        d    = q;
        tick = (q.cnt >= div);
        if (tick) d.cnt = '0;
        else      d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // A non-zero divider never yields ticks on adjacent clocks
    assert_tick_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              done,
    output logic [CHAR_W-1:0] dout,
    output logic              perr,
    output logic              ferr,
    output logic              brk
);
    localparam logic [OS_W-1:0] MID  = OS_W'(OSR/2 - 1);
    localparam logic [OS_W-1:0] LAST = OS_W'(OSR - 1);

    typedef struct packed {
        rx_st_e            st;
        logic [OS_W-1:0]   os;
        logic [2:0]        bitn;
        logic [CHAR_W-1:0] sh;
        logic              par;
        logic              allz;
        logic              stop2;
        logic              frm;
        logic              pbad;
        logic              done;
        logic [CHAR_W-1:0] dout;
        logic              o_perr;
        logic              o_frm;
        logic              o_brk;
    } fr_s;

    fr_s q, d;
    logic [2:0] last_idx;
    logic       bad_stop;
    logic       frm_all;
    logic       zero_all;

    assign last_idx = {1'b0, cfg_len} + 3'd4;
    assign bad_stop = !rx;
    assign frm_all  = q.frm | bad_stop;
    assign zero_all = q.allz & bad_stop;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.o_perr = 1'b0;
        d.o_frm  = 1'b0;
        d.o_brk  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (!rx) begin
                    d.st = ST_START;
                    d.os = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.os == MID) begin
                        if (!rx) begin
                            d.st    = ST_DATA;
                            d.os    = '0;
                            d.bitn  = '0;
                            d.sh    = '0;
                            d.par   = 1'b0;
                            d.allz  = 1'b1;
                            d.stop2 = 1'b0;
                            d.frm   = 1'b0;
                            d.pbad  = 1'b0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    d.os = q.os + 1'b1;
                    if (q.os == LAST) begin
                        d.sh[q.bitn] = rx;
                        d.par        = q.par ^ rx;
                        d.allz       = q.allz & !rx;
                        d.bitn       = q.bitn + 1'b1;
                        if (q.bitn == last_idx)
                            d.st = cfg_par_en ? ST_PAR : ST_STOP;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    d.os = q.os + 1'b1;
                    if (q.os == LAST) begin
                        d.pbad = ((q.par ^ rx) != cfg_par_odd);
                        d.allz = q.allz & !rx;
                        d.st   = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.os = q.os + 1'b1;
                    if (q.os == LAST) begin
                        if (cfg_two_stop && !q.stop2) begin
                            d.stop2 = 1'b1;
                            d.frm   = frm_all;
                            d.allz  = zero_all;
                        end else begin
                            d.done = 1'b1;
                            if (zero_all) begin
                                d.dout  = '0;
                                d.o_brk = 1'b1;
                                d.st    = ST_WAITHI;
                            end else begin
                                d.dout   = q.sh;
                                d.o_perr = q.pbad;
                                d.o_frm  = frm_all;
                                d.st     = frm_all ? ST_WAITHI : ST_IDLE;
                            end
                        end
                    end
                end
            end
            ST_WAITHI: begin
                if (rx) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign dout = q.dout;
    assign perr = q.o_perr;
    assign ferr = q.o_frm;
    assign brk  = q.o_brk;

    // Entering data collection needs the line low at the start mid-point
    assert_start_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && $past(q.st) == ST_START) |-> ($past(rx) == 1'b0));

    // A break is reported alone, with an all-zero character
    assert_brk_alone_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q.o_brk |-> (!q.o_frm && !q.o_perr && q.dout == '0));

    // Error pulses only accompany a finished character
    assert_err_with_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.o_perr || q.o_frm) |-> q.done);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic                         push,
    input  logic [CHAR_W-1:0]            din,
    input  logic                         pop,
    output logic [CHAR_W-1:0]            dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overrun
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][CHAR_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
        logic                         ovr;
    } fifo_s;

    fifo_s q, d;
    logic             do_pop;
    logic             take;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] left;

    always_comb begin
        d      = q;
        d.ovr  = 1'b0;
        cap    = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        do_pop = pop && (q.cnt != '0);
        left   = q.cnt - CNT_W'(do_pop);
        take   = 1'b0;
        if (push) begin
            if (left < cap) begin
                take          = 1'b1;
                d.mem[q.wp]   = din;
                d.wp          = q.wp + 1'b1;
            end else begin
                d.ovr = 1'b1;
            end
        end
        if (do_pop) d.rp = q.rp + 1'b1;
        d.cnt = left + CNT_W'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout    = q.mem[q.rp];
    assign count   = q.cnt;
    assign overrun = q.ovr;

    // Full queue without a read keeps its fill on an incoming character
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && q.cnt == CNT_W'(DEPTH)) |=> (q.cnt == $past(q.cnt)));

    // Single-slot mode never holds more than one character
    assert_single_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!fifo_en) && !fifo_en && $past(q.cnt) <= CNT_W'(1)) |-> (q.cnt <= CNT_W'(1)));
endmodule

// File: rtl/uart_rx_dmareq.sv
module uart_rx_dmareq
    import uart_rx_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_fifo_en,
    input  logic              cfg_dma_sel,
    input  logic [1:0]        cfg_trig,
    input  logic              rx_serial,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rxrdy_n,
    output logic              rx_timeout,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              brk_det
);
    localparam int CNT_W    = $clog2(FIFO_DEPTH + 1);
    localparam int MAX_BITS = 12;
    localparam int TO_W     = $clog2(TO_CHARS * OSR * MAX_BITS + 1);
    localparam logic [CNT_W-1:0] TRIG_A = CNT_W'(1);
    localparam logic [CNT_W-1:0] TRIG_B = CNT_W'(FIFO_DEPTH / 4);
    localparam logic [CNT_W-1:0] TRIG_C = CNT_W'(FIFO_DEPTH / 2);
    localparam logic [CNT_W-1:0] TRIG_D = CNT_W'(FIFO_DEPTH - 2);

    typedef struct packed {
        logic [1:0]      sync;
        logic [TO_W-1:0] to_cnt;
        logic            to_q;
        logic            rdy;
    } top_s;

    top_s q, d;

    logic              tick;
    logic              rx_s;
    logic              f_done;
    logic [CHAR_W-1:0] f_data;
    logic              f_perr;
    logic              f_ferr;
    logic              f_brk;
    logic [CNT_W-1:0]  fill;
    logic              pop;
    logic              batched;
    logic [CNT_W-1:0]  trig_lvl;
    logic [3:0]        fbits;
    logic [TO_W-1:0]   to_limit;

    assign rx_s    = q.sync[1];
    assign pop     = rd_en;
    assign batched = cfg_dma_sel & cfg_fifo_en;

    uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (cfg_div),
        .tick (tick)
    );

    uart_rx_frame frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rx          (rx_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_two_stop(cfg_two_stop),
        .done        (f_done),
        .dout        (f_data),
        .perr        (f_perr),
        .ferr        (f_ferr),
        .brk         (f_brk)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .fifo_en(cfg_fifo_en),
        .push   (f_done),
        .din    (f_data),
        .pop    (pop),
        .dout   (rd_data),
        .count  (fill),
        .overrun(err_overrun)
    );

    always_comb begin
        case (cfg_trig)
            2'd0:    trig_lvl = TRIG_A;
            2'd1:    trig_lvl = TRIG_B;
            2'd2:    trig_lvl = TRIG_C;
            default: trig_lvl = TRIG_D;
        endcase
        fbits    = 4'd6 + {2'b00, cfg_len} + {3'b000, cfg_par_en} + (cfg_two_stop ? 4'd2 : 4'd1);
        to_limit = TO_W'(TO_CHARS * OSR) * TO_W'(fbits);
    end

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rx_serial};
        if (fill == '0 || f_done || pop) begin
            d.to_cnt = '0;
            d.to_q   = 1'b0;
        end else if (tick && !q.to_q) begin
            if (q.to_cnt == to_limit - 1'b1) d.to_q = 1'b1;
            else                             d.to_cnt = q.to_cnt + 1'b1;
        end
        if (batched) begin
            if (q.rdy) d.rdy = (fill != '0);
            else       d.rdy = (fill >= trig_lvl) || q.to_q;
        end else begin
            d.rdy = (fill != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign rd_valid   = (fill != '0);
    assign rxrdy_n    = !q.rdy;
    assign rx_timeout = q.to_q;
    assign err_parity = f_perr;
    assign err_frame  = f_ferr;
    assign brk_det    = f_brk;

    // Simple behaviour: request follows the previous cycle's occupancy
    assert_simple_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!batched && $past(!batched)) |-> (q.rdy == ($past(fill) != '0)));

    // Batched behaviour: request held while anything remains
    assert_hold_until_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (batched && $past(batched) && $past(q.rdy) && $past(fill) != '0) |-> q.rdy);

    // A pending timeout implies held data
    assert_timeout_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.to_q |-> (fill != '0));
endmodule

// File: tb/uart_rx_dmareq_tb.sv
module uart_rx_dmareq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_fifo_en = 1'b1;
    logic        cfg_dma_sel = 1'b0;
    logic [1:0]  cfg_trig = 2'd0;
    logic        rx_serial = 1'b1;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid, rxrdy_n, rx_timeout;
    logic        err_parity, err_frame, err_overrun, brk_det;

    int tests = 0, fails = 0;
    int n_par = 0, n_frm = 0, n_ovr = 0, n_brk = 0;
    int mism = 0, cmp_cycles = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    int exp_ovr = 0;

    always #2 clk = ~clk;

    uart_rx_dmareq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .cfg_fifo_en(cfg_fifo_en), .cfg_dma_sel(cfg_dma_sel), .cfg_trig(cfg_trig),
        .rx_serial(rx_serial), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rxrdy_n(rxrdy_n), .rx_timeout(rx_timeout), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (err_parity)  n_par++;
            if (err_frame)   n_frm++;
            if (err_overrun) n_ovr++;
            if (brk_det)     n_brk++;
        end
    end

    // Per-clock comparison of the simple request against previous occupancy (R8)
    bit pv = 0, pm1 = 0, pm2 = 0;
    always @(negedge clk) begin
        bit m0;
        m0 = !(cfg_dma_sel && cfg_fifo_en);
        if (rst_n && m0 && pm1 && pm2) begin
            cmp_cycles++;
            if (rxrdy_n !== !pv) mism++;
        end
        pv  = rd_valid;
        pm2 = pm1;
        pm1 = m0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bitcyc();
        return 16 * (int'(cfg_div) + 1);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_push(input logic [7:0] v);
        int cap;
        cap = cfg_fifo_en ? 16 : 1;
        if (exp_q.size() < cap) exp_q.push_back(v);
        else exp_ovr++;
    endfunction

    task automatic send(input logic [7:0] dat, input bit flip_par, input bit stop_low);
        int nb;
        logic p;
        logic [7:0] v;
        nb = int'(cfg_len) + 5;
        v = dat & 8'((1 << nb) - 1);
        p = cfg_par_odd;
        rx_serial = 1'b0;
        wait_cyc(bitcyc());
        for (int i = 0; i < nb; i++) begin
            rx_serial = v[i];
            p = p ^ v[i];
            wait_cyc(bitcyc());
        end
        if (cfg_par_en) begin
            rx_serial = p ^ flip_par;
            wait_cyc(bitcyc());
        end
        for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
            rx_serial = !stop_low;
            wait_cyc(bitcyc());
        end
        rx_serial = 1'b1;
        model_push(v);
    endtask

    task automatic rd_check(input string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_valid === 1'b1 && rd_data === e, req, int'(rd_data), int'(e));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int b;
        wait_cyc(5);
        chk(rxrdy_n === 1'b1 && rd_valid === 1'b0 && rx_timeout === 1'b0, "R8 reset", int'(rxrdy_n), 1);
        rst_n = 1'b1;
        wait_cyc(5);

        // R1: 8 data bits, no parity
        send(8'hA5, 0, 0); wait_cyc(16);
        rd_check("R1 8-bit char");
        // R1: 5 data bits, upper bits zero
        cfg_len = 2'd0; wait_cyc(2);
        send(8'hF5, 0, 0); wait_cyc(16);
        rd_check("R1 5-bit char");

        // R2: 7 data, even parity, 2 stop, back to back
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_two_stop = 1'b1; wait_cyc(2);
        b = n_par;
        send(8'h41, 0, 0); send(8'h7F, 0, 0); send(8'h00, 0, 0); wait_cyc(16);
        chk(n_par == b, "R2 no parity errors", n_par - b, 0);
        rd_check("R2 first"); rd_check("R2 second"); rd_check("R2 third");

        // R3: odd parity, wrong bit
        cfg_par_odd = 1'b1; wait_cyc(2);
        b = n_par;
        send(8'h33, 0, 0); wait_cyc(16);
        chk(n_par == b, "R3 odd parity good", n_par - b, 0);
        send(8'h33, 1, 0); wait_cyc(16);
        chk(n_par == b + 1, "R3 parity error pulse", n_par - b, 1);
        rd_check("R3 good char"); rd_check("R3 bad-parity char kept");
        cfg_par_odd = 1'b0;

        // R4: stop bit low
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; wait_cyc(2);
        b = n_frm;
        send(8'h5A, 0, 1); wait_cyc(32);
        chk(n_frm == b + 1, "R4 framing pulse", n_frm - b, 1);
        rd_check("R4 char stored");

        // R5: short glitch
        rx_serial = 1'b0; wait_cyc(5); rx_serial = 1'b1; wait_cyc(300);
        chk(rd_valid === 1'b0, "R5 glitch ignored", int'(rd_valid), 0);

        // R12: break
        b = n_brk;
        begin
            int f;
            f = n_frm;
            rx_serial = 1'b0; wait_cyc(12 * bitcyc());
            rx_serial = 1'b1; wait_cyc(2 * bitcyc());
            chk(n_brk == b + 1 && n_frm == f, "R12 break pulse only", n_brk - b, 1);
        end
        exp_q.push_back(8'h00);
        rd_check("R12 zero char");

        // R6/R7: single slot
        cfg_fifo_en = 1'b0; wait_cyc(2);
        b = n_ovr;
        send(8'h11, 0, 0); send(8'h22, 0, 0); wait_cyc(16);
        chk(n_ovr == b + 1, "R7 single-slot overrun", n_ovr - b, 1);
        rd_check("R6 single slot keeps first");
        wait_cyc(2);
        chk(rd_valid === 1'b0, "R6 single slot empty", int'(rd_valid), 0);

        // R6/R7: queue of 16, 17th dropped
        cfg_fifo_en = 1'b1; wait_cyc(2);
        b = n_ovr;
        for (int i = 0; i < 17; i++) send(8'(8'h30 + i), 0, 0);
        wait_cyc(16);
        chk(n_ovr == b + 1, "R7 queue overrun", n_ovr - b, 1);
        for (int i = 0; i < 16; i++) rd_check("R6 queue order");
        wait_cyc(2);
        chk(rd_valid === 1'b0, "R7 contents preserved then empty", int'(rd_valid), 0);

        // R9/R11: batched, threshold 4, 7P2
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_two_stop = 1'b1;
        cfg_dma_sel = 1'b1; cfg_trig = 2'd1; wait_cyc(4);
        send(8'h01, 0, 0); send(8'h02, 0, 0); send(8'h03, 0, 0); wait_cyc(16);
        chk(rxrdy_n === 1'b1, "R9 below threshold", int'(rxrdy_n), 1);
        send(8'h04, 0, 0); wait_cyc(16);
        chk(rxrdy_n === 1'b0, "R9 threshold reached", int'(rxrdy_n), 0);
        rd_check("R11 read1"); rd_check("R11 read2"); wait_cyc(2);
        chk(rxrdy_n === 1'b0, "R11 held below threshold", int'(rxrdy_n), 0);
        rd_check("R11 read3"); rd_check("R11 read4"); wait_cyc(3);
        chk(rxrdy_n === 1'b1, "R11 released when empty", int'(rxrdy_n), 1);

        // R10: timeout, threshold 8, 11-bit frame -> 704 ticks
        cfg_trig = 2'd2; wait_cyc(2);
        send(8'h6B, 0, 0);
        wait_cyc(650);
        chk(rxrdy_n === 1'b1 && rx_timeout === 1'b0, "R10 before timeout", int'(rx_timeout), 0);
        wait_cyc(100);
        chk(rxrdy_n === 1'b0 && rx_timeout === 1'b1, "R10 timeout asserts request", int'(rxrdy_n), 0);
        rd_check("R10 read"); wait_cyc(3);
        chk(rxrdy_n === 1'b1 && rx_timeout === 1'b0, "R10 cleared", int'(rxrdy_n), 1);

        // R13: divider 2
        cfg_dma_sel = 1'b0; cfg_trig = 2'd0;
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; cfg_div = 16'd2; wait_cyc(4);
        send(8'h3C, 0, 0); wait_cyc(48);
        rd_check("R13 divided bit time");
        cfg_div = 16'd0; wait_cyc(4);

        chk(n_ovr == exp_ovr, "R7 overrun count model", n_ovr, exp_ovr);
        chk(mism == 0 && cmp_cycles > 0, "R8 per-clock request compare", mism, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule